// File: doc/BRIEF.md
# Synchronous Character Receiver with Sync Hunt

This block is the receive half of a synchronous serial port. A qualifier pulse (`bit_en`) marks each receive-clock bit time, and on each such pulse the block samples one bit of `rxd`, least significant bit first. After a hunt command it looks for a programmed sync pattern, checking it on every bit shift. That pattern is either one sync character, or two sync characters that must arrive back to back. Once the pattern is found, the block cuts the bits that follow into characters of 5 to 8 bits, each with an optional parity bit. It delivers every character with a ready flag and records parity and overrun faults.

A mode byte sets the character length, parity, single or double sync, and the source of alignment. When the sync detect pin is an output, the block drives it high on an internal pattern match. When the pin is an input, a rising edge on it ends the hunt and framing starts with the next bit. Sync characters are presented as static pattern inputs.

The control state machine has four states:
- `ST_IDLE`: the state after reset or after a mode write. Nothing is framed here.
- `ST_HUNT_A`: entered from any state on `hunt_cmd`, and from `ST_HUNT_B` when the second sync character mismatches. In internal mode the block searches for the first sync character. In external mode it waits for a rising edge on the detect pin.
- `ST_HUNT_B`: entered on a first-character match when double sync is selected. The next character's worth of bits is compared with the second sync character.
- `ST_FRAME`: entered on a full match or on an external edge. Characters are assembled continuously until a mode write or a new hunt command.

Top module: `rxs_sync_rx`

## Requirements
- R1: After reset, `rx_ready`, `parity_err`, `overrun_err` and `syndet_out` are 0, the mode is all zero, and `syndet_oe` is 1.
- R2: The mode byte is decoded as follows: bits [1:0]=00 select synchronous mode; bits [3:2] select the length (00=5, 01=6, 10=7, 11=8 bits); bit 4 enables parity; bit 5 selects even (1) or odd (0) parity; bit 6 selects external sync (1); bit 7 selects single sync (1) or double sync (0). A mode write returns the block to `ST_IDLE`.
- R3: With single sync in internal mode, the hunt compares the most recent N bits (N = the character length) with the low N bits of `sync_pat_a` after every bit, at any alignment. Only bits received since the hunt began count toward the match. On a match, `syndet_out` is 1 after the matching bit's clock edge.
- R4: With double sync, the N bits that immediately follow a first-character match must equal the low N bits of `sync_pat_b`. On a mismatch the hunt starts over on the first character and `syndet_out` stays 0.
- R5: After sync, characters follow back to back, LSB first. `rx_data` holds the N bits with all higher bits 0, and `rx_ready` rises on the edge of the character's last bit.
- R6: With parity enabled, one parity bit follows the N data bits. Even parity makes the count of ones in the data plus parity even; odd parity makes it odd. A mismatch sets `parity_err`, which stays set until `err_clr`.
- R7: If a character completes while `rx_ready` is 1 and no read happens in that cycle, `overrun_err` is set and `rx_data` takes the new character. `err_clr` clears the flag.
- R8: `status_rd` clears `syndet_out`. `syndet_oe` is 1 exactly when internal sync is selected.
- R9: In external mode, a rising edge of `syndet_in` during the hunt moves the block to framing, and the first data bit is the next `bit_en` bit. `syndet_out` never rises in this mode.
- R10: Bits received in `ST_IDLE` produce neither characters nor a sync detect.
- R11: `rx_data_rd` clears `rx_ready` on the next edge, unless a character completes in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per receive bit time |
| rxd | input | 1 | Serial data, sampled when `bit_en` is 1 |
| mode_wr | input | 1 | Load the mode byte |
| mode_data | input | 8 | Mode byte (see R2) |
| sync_pat_a | input | DW | First sync character |
| sync_pat_b | input | DW | Second sync character |
| hunt_cmd | input | 1 | Start a sync hunt |
| err_clr | input | 1 | Clear the parity and overrun flags |
| status_rd | input | 1 | Status read strobe; clears `syndet_out` |
| rx_data_rd | input | 1 | Data read strobe; clears `rx_ready` |
| syndet_in | input | 1 | External sync detect |
| syndet_out | output | 1 | Internal sync detect |
| syndet_oe | output | 1 | Output enable for the sync detect pin |
| rx_data | output | DW | Received character |
| rx_ready | output | 1 | Character available |
| parity_err | output | 1 | Sticky parity fault |
| overrun_err | output | 1 | Sticky overrun fault |

## Verification
The bench sends a wrong second sync character right after a good first one. A design that accepted the first character alone would raise sync detect and then frame garbage. It also sends the same pattern before any hunt command, which catches a design that matches while idle. Characters shorter than 8 bits are sent from bytes whose high bits are set, so a missing mask shows up as wrong upper data bits. A deliberately wrong parity bit and two unread characters in a row check the sticky flags; a wrong parity sense or a lost overrun would go undetected without them. In external mode the bench leaves junk bits ahead of the detect edge, and any misplaced framing start shifts every character that follows.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HUNT_A = 2'd1,
        ST_HUNT_B = 2'd2,
        ST_FRAME  = 2'd3
    } rx_state_e;

    // Mode byte layout (R2); bit order matters to software writing it
    typedef struct packed {
        logic       single_sync;
        logic       ext_sync;
        logic       even_par;
        logic       par_en;
        logic [1:0] len_sel;
        logic [1:0] kind;
    } rx_mode_t;

endpackage

// File: rtl/rxs_bit_shift.sv
module rxs_bit_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          din,
    output logic [DW-1:0] hist_q,
    output logic [DW-1:0] hist_nx
);
    // newest bit enters at the top so a finished LSB-first character
    // sits in the upper bits
    assign hist_nx = {din, hist_q[DW-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= hist_nx;
        end
    end
endmodule

// File: rtl/rxs_sync_cmp.sv
module rxs_sync_cmp #(
    parameter int DW = 8,
    parameter int CW = 4
) (
    input  logic [DW-1:0] window,
    input  logic [DW-1:0] pattern,
    input  logic [CW-1:0] shamt,
    output logic          hit
);
    logic [DW-1:0] mask;
    logic [DW-1:0] aligned;

    assign mask    = {DW{1'b1}} >> shamt;
    assign aligned = window >> shamt;
    assign hit     = (aligned == (pattern & mask));
endmodule

// File: rtl/rxs_par_chk.sv
module rxs_par_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          even_par,
    input  logic          pbit,
    output logic          bad
);
    logic expect_bit;

    assign expect_bit = even_par ? (^data) : ~(^data);
    assign bad        = (pbit != expect_bit);
endmodule

// File: rtl/rxs_sync_rx.sv
module rxs_sync_rx #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          rxd,
    input  logic          mode_wr,
    input  logic [7:0]    mode_data,
    input  logic [DW-1:0] sync_pat_a,
    input  logic [DW-1:0] sync_pat_b,
    input  logic          hunt_cmd,
    input  logic          err_clr,
    input  logic          status_rd,
    input  logic          rx_data_rd,
    input  logic          syndet_in,
    output logic          syndet_out,
    output logic          syndet_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          parity_err,
    output logic          overrun_err
);
    import rxs_pkg::*;

    localparam int CW     = $clog2(DW + 1);
    localparam int NPAT   = 2;
    localparam int MINLEN = 5;

    rx_mode_t      mode_q;
    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          par_q, par_d;
    logic          ext_prev_q;
    logic          syndet_q, ready_q, pe_q, oe_q;
    logic [DW-1:0] data_q;

    logic [CW-1:0] nbits, shamt;
    logic          ext_rise;
    logic          shift_en;
    logic [DW-1:0] hist_q, hist_nx;
    logic [DW-1:0] char_word, char_data;
    logic [NPAT-1:0]         hit;
    logic [NPAT-1:0][DW-1:0] pats;
    logic          char_done, sync_evt, par_bad;

    assign nbits    = CW'(MINLEN) + CW'(mode_q.len_sel);
    assign shamt    = CW'(DW) - nbits;
    assign ext_rise = syndet_in & ~ext_prev_q;
    // the parity bit does not enter the character shifter
    assign shift_en = bit_en & ~((state_q == ST_FRAME) & par_q);

    rxs_bit_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (rxd),
        .hist_q   (hist_q),
        .hist_nx  (hist_nx)
    );

    assign pats[0] = sync_pat_a;
    assign pats[1] = sync_pat_b;

    for (genvar g = 0; g < NPAT; g++) begin : g_cmp
        rxs_sync_cmp #(.DW(DW), .CW(CW)) u_cmp (
            .window  (hist_nx),
            .pattern (pats[g]),
            .shamt   (shamt),
            .hit     (hit[g])
        );
    end

    assign char_word = par_q ? hist_q : hist_nx;
    assign char_data = char_word >> shamt;

    rxs_par_chk #(.DW(DW)) u_par (
        .data     (char_data),
        .even_par (mode_q.even_par),
        .pbit     (rxd),
        .bad      (par_bad)
    );

    // next-state logic
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        par_d     = par_q;
        char_done = 1'b0;
        sync_evt  = 1'b0;
        if (mode_wr) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            par_d   = 1'b0;
        end else if (hunt_cmd) begin
            state_d = ST_HUNT_A;
            cnt_d   = '0;
            par_d   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_HUNT_A: begin
                    if (mode_q.ext_sync) begin
                        if (ext_rise) begin
                            state_d = ST_FRAME;
                            cnt_d   = '0;
                        end
                    end else if (bit_en) begin
                        if ((cnt_q >= nbits - CW'(1)) && hit[0]) begin
                            cnt_d = '0;
                            if (mode_q.single_sync) begin
                                state_d  = ST_FRAME;
                                sync_evt = 1'b1;
                            end else begin
                                state_d = ST_HUNT_B;
                            end
                        end else if (cnt_q < nbits) begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_HUNT_B: begin
                    if (bit_en) begin
                        if (cnt_q == nbits - CW'(1)) begin
                            cnt_d = '0;
                            if (hit[1]) begin
                                state_d  = ST_FRAME;
                                sync_evt = 1'b1;
                            end else begin
                                state_d = ST_HUNT_A;
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
                ST_FRAME: begin
                    if (bit_en) begin
                        if (par_q) begin
                            par_d     = 1'b0;
                            char_done = 1'b1;
                        end else if (cnt_q == nbits - CW'(1)) begin
                            cnt_d = '0;
                            if (mode_q.par_en) begin
                                par_d = 1'b1;
                            end else begin
                                char_done = 1'b1;
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            par_q   <= par_d;
        end
    end

    // outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= '0;
            ext_prev_q <= 1'b0;
            syndet_q   <= 1'b0;
            ready_q    <= 1'b0;
            pe_q       <= 1'b0;
            oe_q       <= 1'b0;
            data_q     <= '0;
        end else begin
            ext_prev_q <= syndet_in;
            if (mode_wr) begin
                mode_q <= rx_mode_t'(mode_data);
            end
            if (status_rd) begin
                syndet_q <= 1'b0;
            end
            if (sync_evt) begin
                syndet_q <= 1'b1;
            end
            if (err_clr) begin
                pe_q <= 1'b0;
                oe_q <= 1'b0;
            end
            if (char_done) begin
                data_q  <= char_data;
                ready_q <= 1'b1;
                if (ready_q && !rx_data_rd) begin
                    oe_q <= 1'b1;
                end
                if (mode_q.par_en && par_bad) begin
                    pe_q <= 1'b1;
                end
            end else if (rx_data_rd) begin
                ready_q <= 1'b0;
            end
        end
    end

    assign syndet_out  = syndet_q;
    assign syndet_oe   = ~mode_q.ext_sync;
    assign rx_data     = data_q;
    assign rx_ready    = ready_q;
    assign parity_err  = pe_q;
    assign overrun_err = oe_q;

endmodule

// File: rtl/rxs_sync_rx_chk.sv
module rxs_sync_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rx_data_rd,
    input logic status_rd,
    input logic rx_ready,
    input logic parity_err,
    input logic overrun_err,
    input logic syndet_out,
    input logic syndet_oe
);
    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(bit_en));

    // R11
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data_rd && !bit_en) |=> !rx_ready);

    // R7
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> $past(rx_ready));

    // R6
    parity_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> $past(bit_en));

    // R3
    syndet_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syndet_out) |-> $past(bit_en));

    // R8
    syndet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(syndet_out) |-> $past(status_rd));

    // R9
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !syndet_oe |-> !$rose(syndet_out));
endmodule

bind rxs_sync_rx rxs_sync_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .rx_data_rd  (rx_data_rd),
    .status_rd   (status_rd),
    .rx_ready    (rx_ready),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .syndet_out  (syndet_out),
    .syndet_oe   (syndet_oe)
);

// File: tb/tb_rxs_sync_rx.sv
module tb_rxs_sync_rx;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0, rxd = 1'b1;
    logic          mode_wr = 1'b0;
    logic [7:0]    mode_data = '0;
    logic [DW-1:0] sync_pat_a = '0, sync_pat_b = '0;
    logic          hunt_cmd = 1'b0, err_clr = 1'b0, status_rd = 1'b0;
    logic          rx_data_rd = 1'b0, syndet_in = 1'b0;
    logic          syndet_out, syndet_oe, rx_ready, parity_err, overrun_err;
    logic [DW-1:0] rx_data;

    typedef struct packed {
        logic [7:0] data;
        logic       pe;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    hold_reads = 1'b0;
    bit    rd_pend = 1'b0;

    always #2 clk = ~clk;

    rxs_sync_rx #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rxd(rxd),
        .mode_wr(mode_wr), .mode_data(mode_data),
        .sync_pat_a(sync_pat_a), .sync_pat_b(sync_pat_b),
        .hunt_cmd(hunt_cmd), .err_clr(err_clr), .status_rd(status_rd),
        .rx_data_rd(rx_data_rd), .syndet_in(syndet_in),
        .syndet_out(syndet_out), .syndet_oe(syndet_oe), .rx_data(rx_data),
        .rx_ready(rx_ready), .parity_err(parity_err), .overrun_err(overrun_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    task automatic write_mode(input logic [7:0] m);
        @(negedge clk) mode_data = m; mode_wr = 1'b1;
        @(negedge clk) mode_wr = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) rxd = b; bit_en = 1'b1;
        @(negedge clk) bit_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) send_bit(v[i]);
    endtask

    task automatic send_char(input logic [7:0] v, input int n, input bit pen,
                             input bit even, input bit flip, input bit push,
                             input bit exp_pe);
        logic [7:0] m;
        logic       p;
        item_t      it;
        m = v & ((8'd1 << n) - 8'd1);
        p = even ? ^m : ~(^m);
        if (push) begin
            it.data = m;
            it.pe   = exp_pe;
            q.push_back(it);
        end
        send_bits(v, n);
        if (pen) send_bit(p ^ flip);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: pops expected items as characters appear
    initial begin
        forever begin
            @(negedge clk);
            if (rd_pend) begin
                rx_data_rd = 1'b0;
                rd_pend    = 1'b0;
                // R11
                check(rx_ready == 1'b0, "R11 ready cleared by read", int'(rx_ready), 0);
            end else if (rx_ready && !hold_reads) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 unexpected character", int'(rx_data), 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    // R5
                    check(rx_data == it.data, "R5 character data", int'(rx_data), int'(it.data));
                    // R6
                    check(parity_err == it.pe, "R6 parity flag", int'(parity_err), int'(it.pe));
                end
                rx_data_rd = 1'b1;
                rd_pend    = 1'b1;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(rx_ready == 0 && parity_err == 0 && overrun_err == 0, "R1 flags after reset",
              int'({rx_ready, parity_err, overrun_err}), 0);
        check(syndet_out == 0 && syndet_oe == 1, "R1 sync detect after reset",
              int'({syndet_out, syndet_oe}), 1);

        // single sync, 8 bits, no parity: mode 8'h8C
        sync_pat_a = 8'h16;
        write_mode(8'h8C);
        // R2
        check(syndet_oe == 1, "R2 internal sync selected", int'(syndet_oe), 1);
        // R10: pattern and data while idle
        send_bits(8'h16, 8);
        send_bits(8'hA5, 8);
        check(rx_ready == 0 && syndet_out == 0, "R10 idle ignores bits",
              int'({rx_ready, syndet_out}), 0);

        // R3: hunt with junk bits ahead of the pattern
        pulse(hunt_cmd);
        send_bits(8'h07, 3);
        check(syndet_out == 0, "R3 no early match", int'(syndet_out), 0);
        send_bits(8'h16, 8);
        check(syndet_out == 1, "R3 single sync detected", int'(syndet_out), 1);
        send_char(8'hA5, 8, 0, 0, 0, 1, 0);
        send_char(8'h3C, 8, 0, 0, 0, 1, 0);
        drain();
        pulse(status_rd);
        @(negedge clk);
        // R8
        check(syndet_out == 0, "R8 status read clears detect", int'(syndet_out), 0);

        // double sync, 6 bits, even parity: mode 8'h34
        sync_pat_a = 8'h2A;
        sync_pat_b = 8'h15;
        write_mode(8'h34);
        pulse(hunt_cmd);
        send_bits(8'h2A, 6);
        send_bits(8'h3F, 6);
        // R4
        check(syndet_out == 0, "R4 wrong second sync rejected", int'(syndet_out), 0);
        send_bits(8'h2A, 6);
        send_bits(8'h15, 6);
        check(syndet_out == 1, "R4 double sync detected", int'(syndet_out), 1);
        send_char(8'hEB, 6, 1, 1, 0, 1, 0);
        send_char(8'h07, 6, 1, 1, 0, 1, 0);
        send_char(8'h11, 6, 1, 1, 1, 1, 1);
        drain();
        // R6
        check(parity_err == 1, "R6 parity flag sticky", int'(parity_err), 1);
        pulse(err_clr);
        @(negedge clk);
        check(parity_err == 0, "R6 flag cleared", int'(parity_err), 0);
        pulse(status_rd);

        // single sync, 5 bits, odd parity: mode 8'h90
        sync_pat_a = 8'h19;
        write_mode(8'h90);
        pulse(hunt_cmd);
        send_bits(8'h19, 5);
        send_char(8'h1F, 5, 1, 0, 0, 1, 0);
        send_char(8'hEA, 5, 1, 0, 0, 1, 0);
        drain();
        // R7: two characters without a read
        hold_reads = 1'b1;
        send_char(8'h03, 5, 1, 0, 0, 0, 0);
        send_char(8'h1C, 5, 1, 0, 0, 1, 0);
        check(overrun_err == 1, "R7 overrun flagged", int'(overrun_err), 1);
        check(rx_data == 8'h1C, "R7 newest character kept", int'(rx_data), 8'h1C);
        hold_reads = 1'b0;
        drain();
        pulse(err_clr);
        @(negedge clk);
        check(overrun_err == 0, "R7 overrun cleared", int'(overrun_err), 0);
        pulse(status_rd);
        @(negedge clk);

        // external sync, 8 bits: mode 8'hCC
        write_mode(8'hCC);
        // R9
        check(syndet_oe == 0, "R9 detect pin is input", int'(syndet_oe), 0);
        pulse(hunt_cmd);
        send_bits(8'h05, 3);
        check(rx_ready == 0, "R9 no framing before edge", int'(rx_ready), 0);
        @(negedge clk) syndet_in = 1'b1;
        repeat (2) @(negedge clk);
        send_char(8'h5A, 8, 0, 0, 0, 1, 0);
        send_char(8'hC3, 8, 0, 0, 0, 1, 0);
        drain();
        syndet_in = 1'b0;
        check(syndet_out == 0, "R9 detect output stays low", int'(syndet_out), 0);
        check(q.size() == 0, "R5 all characters delivered", q.size(), 0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule